// File: doc/BRIEF.md
# Endpoint FIFO Memory Allocator

This block holds one configuration entry for each of sixteen endpoint slots (slot 0 is the control OUT endpoint, slot 1 the control IN endpoint, slots 2 to 15 are endpoints 1 to 14). It also carves a shared FIFO memory of `MEM_BYTES` bytes into one contiguous region per enabled endpoint. Software writes the slots through command codes 20h + slot and reads them back through codes 30h + slot. The block recomputes the memory map only after one complete pass that writes every slot in ascending order, ending with slot 15.

When the ordered pass ends, a walker visits the slots in ascending order, one per cycle. Each slot's base is the running total of the footprints of the slots before it. Any slot that does not fit is reported as invalid, and an overflow flag is raised. A write that alters a slot's enable, size code or double-buffer bit invalidates the data of every endpoint, and the block signals this with a one-cycle pulse. A bus reset disables all slots and drops the allocation.

The controller has three states. `ST_COLLECT` tracks the ordered pass. `ST_WALK` computes the map. `ST_READY` publishes it. The transitions are:
- pass-complete: `ST_COLLECT` to `ST_WALK`, on an in-order write to slot 15.
- walk-end: `ST_WALK` to `ST_READY`, after slot 15 is visited.
- abort: `ST_WALK` or `ST_READY` to `ST_COLLECT`, on any accepted write.
- bus-reset: any state to `ST_COLLECT`.

Top module: `ep_fifo_allocator`

## Requirements
- R1: After reset, `alloc_done`, `alloc_overflow` and `ep_valid` are 0. Reading slot 0 (code 30h) returns 30h, reading slot 1 (code 31h) returns 32h, and reading slots 2 to 15 returns 00h.
- R2: The config byte layout is:
  - bit 0: enable.
  - bit 1: direction (1 = IN).
  - bit 2: double-buffer.
  - bit 3: isochronous (0 = bulk/interrupt).
  - bits 6:4: size code, where the FIFO size is 8 << code bytes.
  - bit 7: stored as 0.

  Codes 20h+i write slot i and codes 30h+i read slot i. A read with any other code returns 00h. A write with a code outside 20h to 2Fh changes nothing and does not drop `alloc_done`.
- R3: Slots 0 and 1 ignore the written data. Any write to slot 0 stores 31h, and any write to slot 1 stores 33h (enabled, 64 bytes, single-buffered, with the slot's fixed direction).
- R4: `alloc_done` rises only after slots 0 to 15 have been written consecutively in ascending order. It is high within 20 cycles of the slot 15 write. A write out of order restarts the tracker: a write to slot 0 begins a new pass, and any other slot resets the tracker to expect slot 0.
- R5: A slot's footprint is (8 << size code) << double-buffer if the slot is enabled, and 0 if it is disabled. `ep_size` reports the footprint. `ep_base` of slot i is the sum of the footprints of all slots below i.
- R6: A slot is valid when it is enabled and base + footprint <= `MEM_BYTES`. `alloc_overflow` is 1 when any enabled slot does not fit. Both are published only while `alloc_done` is high.
- R7: In the cycle after any accepted write, `alloc_done` is 0 and all `ep_valid` bits are 0. This holds both for a write while the map is published and for a write during the walk, which aborts the walk.
- R8: `contents_inv` pulses for one cycle after a write whose stored enable, size code or double-buffer value differs from the old one. A write that changes only the direction or the type bit produces no pulse.
- R9: `bus_reset` takes priority over a write in the same cycle. It clears the enable bit of every slot, drops `alloc_done`, `ep_valid` and `alloc_overflow`, restarts the tracker, and pulses `contents_inv` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for one configuration command |
| cfg_code | input | 8 | Write command code, 20h + slot |
| cfg_data | input | 8 | Configuration byte to store |
| rd_code | input | 8 | Read command code, 30h + slot |
| rd_data | output | 8 | Stored configuration of the addressed slot (combinational) |
| bus_reset | input | 1 | Bus reset strobe |
| ep_base | output | NUM_EP*BASE_W | Byte base of each slot, slot i at bits i*BASE_W |
| ep_size | output | NUM_EP*SIZE_W | Footprint in bytes of each slot, slot i at bits i*SIZE_W |
| ep_valid | output | NUM_EP | Slot has a region inside the memory |
| alloc_done | output | 1 | Map computed from a complete ordered pass |
| alloc_overflow | output | 1 | At least one enabled slot did not fit |
| contents_inv | output | 1 | One-cycle pulse: all FIFO contents are now invalid |

## Verification
The allocation is driven first with a mixed map, and then with the same map after one large slot is disabled. The mixed map contains disabled slots, double-buffered slots, a slot that ends exactly at the capacity and a slot one past it, so it separates footprint arithmetic, base accumulation and the fit boundary. Disabling the large slot shows whether the later bases shift down and whether the overflow clears.

The sequence tracker is tried three ways: with a complete ordered pass, with a pass that skips one slot, and with a write that lands during the walk. These tell a true ordered-pass detector from one that only watches for slot 15. Single writes that change only the direction, only the size, or only the enable bit separate the invalidation pulse from plain write activity. Writes to the control slots, and writes with out-of-range codes, show that those slots and those codes leave the stored state alone.

// File: rtl/epalloc_pkg.sv
package epalloc_pkg;

    localparam logic [7:0] WR_CODE_BASE = 8'h20;
    localparam logic [7:0] RD_CODE_BASE = 8'h30;
    localparam int unsigned CTRL_SIZE_CODE = 3;

    typedef struct packed {
        logic       rsvd;
        logic [2:0] size_code;
        logic       iso;
        logic       dbuf;
        logic       dir_in;
        logic       en;
    } ep_cfg_t;

    typedef enum logic [1:0] {
        ST_COLLECT,
        ST_WALK,
        ST_READY
    } alloc_state_e;

    function automatic int unsigned fifo_bytes(input logic [2:0] code);
        return 32'd8 << code;
    endfunction

    function automatic int unsigned footprint(input ep_cfg_t c);
        if (!c.en) return 32'd0;
        return fifo_bytes(c.size_code) << c.dbuf;
    endfunction

    function automatic ep_cfg_t ctrl_default(input logic dir_in, input logic en);
        ep_cfg_t c;
        c           = '0;
        c.size_code = 3'(CTRL_SIZE_CODE);
        c.dir_in    = dir_in;
        c.en        = en;
        return c;
    endfunction

    function automatic logic layout_changed(input ep_cfg_t a, input ep_cfg_t b);
        return (a.en != b.en) || (a.size_code != b.size_code) || (a.dbuf != b.dbuf);
    endfunction

endpackage

// File: rtl/epalloc_cfg_table.sv
module epalloc_cfg_table
    import epalloc_pkg::*;
#(
    parameter int unsigned NUM_EP = 16,
    parameter int unsigned IDX_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_acc,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [7:0]           wr_data,
    input  logic                 bus_reset,
    input  logic [7:0]           rd_code,
    output logic [7:0]           rd_data,
    output ep_cfg_t [NUM_EP-1:0] cfg_all,
    output logic                 inv_pulse
);

    localparam logic [8:0] RD_END = 9'(32'h30 + NUM_EP);

    ep_cfg_t [NUM_EP-1:0] cfg_q;
    ep_cfg_t              new_val;
    ep_cfg_t              old_val;
    logic    [7:0]        rd_off;
    logic                 rd_hit;
    logic                 inv_q;

    // Value a write would store in the addressed slot
    always_comb begin
        if (wr_idx < IDX_W'(2)) begin
            new_val = ctrl_default(wr_idx[0], 1'b1);
        end else begin
            new_val      = ep_cfg_t'(wr_data);
            new_val.rsvd = 1'b0;
        end
        old_val = cfg_q[wr_idx];
    end

    // One storage slot per endpoint; control slots keep fixed contents
    for (genvar g = 0; g < NUM_EP; g++) begin : g_slot
        if (g < 2) begin : g_ctrl
            localparam ep_cfg_t CTRL_OFF = ctrl_default(1'(g), 1'b0);
            localparam ep_cfg_t CTRL_ON  = ctrl_default(1'(g), 1'b1);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cfg_q[g] <= CTRL_OFF;
                end else if (bus_reset) begin
                    cfg_q[g] <= CTRL_OFF;
                end else if (wr_acc && wr_idx == IDX_W'(g)) begin
                    cfg_q[g] <= CTRL_ON;
                end
            end
        end else begin : g_user
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cfg_q[g] <= '0;
                end else if (bus_reset) begin
                    cfg_q[g].en <= 1'b0;
                end else if (wr_acc && wr_idx == IDX_W'(g)) begin
                    cfg_q[g] <= new_val;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inv_q <= 1'b0;
        end else begin
            inv_q <= bus_reset || (wr_acc && layout_changed(old_val, new_val));
        end
    end

    // Read port
    always_comb begin
        rd_off = rd_code - RD_CODE_BASE;
        rd_hit = (rd_code >= RD_CODE_BASE) && ({1'b0, rd_code} < RD_END);
        rd_data = rd_hit ? 8'(cfg_q[rd_off[IDX_W-1:0]]) : 8'h00;
    end

    assign cfg_all   = cfg_q;
    assign inv_pulse = inv_q;

endmodule

// File: rtl/epalloc_ctrl.sv
module epalloc_ctrl
    import epalloc_pkg::*;
#(
    parameter int unsigned NUM_EP = 16,
    parameter int unsigned IDX_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_acc,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             bus_reset,
    output logic             walk_step,
    output logic [IDX_W-1:0] walk_idx,
    output logic             alloc_done
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_EP - 1);

    alloc_state_e     state_q;
    alloc_state_e     state_d;
    logic [IDX_W-1:0] expect_q;
    logic [IDX_W-1:0] walk_q;
    logic             in_order;

    assign in_order = (state_q == ST_COLLECT) && (wr_idx == expect_q);

    // Next-state logic with named transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COLLECT: begin
                // pass-complete
                if (wr_acc && in_order && wr_idx == LAST_IDX) state_d = ST_WALK;
            end
            ST_WALK: begin
                if (wr_acc)                     state_d = ST_COLLECT; // abort
                else if (walk_q == LAST_IDX)    state_d = ST_READY;   // walk-end
            end
            ST_READY: begin
                if (wr_acc)                     state_d = ST_COLLECT; // abort
            end
            default: state_d = ST_COLLECT;
        endcase
        if (bus_reset) state_d = ST_COLLECT;                          // bus-reset
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_COLLECT;
        else        state_q <= state_d;
    end

    // Ordered-pass tracker
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            expect_q <= '0;
        end else if (bus_reset) begin
            expect_q <= '0;
        end else if (wr_acc) begin
            if (in_order) begin
                expect_q <= (wr_idx == LAST_IDX) ? '0 : wr_idx + IDX_W'(1);
            end else begin
                expect_q <= (wr_idx == '0) ? IDX_W'(1) : '0;
            end
        end
    end

    // Walk index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walk_q <= '0;
        end else if (state_q != ST_WALK) begin
            walk_q <= '0;
        end else if (walk_step) begin
            walk_q <= walk_q + IDX_W'(1);
        end
    end

    // Outputs
    always_comb begin
        walk_step  = 1'b0;
        alloc_done = 1'b0;
        unique case (state_q)
            ST_COLLECT: ;
            ST_WALK:    walk_step  = !wr_acc && !bus_reset;
            ST_READY:   alloc_done = 1'b1;
            default: ;
        endcase
    end

    assign walk_idx = walk_q;

endmodule

// File: rtl/epalloc_walker.sv
module epalloc_walker
    import epalloc_pkg::*;
#(
    parameter int unsigned NUM_EP    = 16,
    parameter int unsigned IDX_W     = 4,
    parameter int unsigned MEM_BYTES = 2048,
    parameter int unsigned BASE_W    = 16,
    parameter int unsigned SIZE_W    = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       step,
    input  logic [IDX_W-1:0]           idx,
    input  ep_cfg_t [NUM_EP-1:0]       cfg_all,
    output logic [NUM_EP*BASE_W-1:0]   base_flat,
    output logic [NUM_EP*SIZE_W-1:0]   size_flat,
    output logic [NUM_EP-1:0]          valid,
    output logic                       overflow
);

    localparam logic [BASE_W:0] MEM_LIM = (BASE_W + 1)'(MEM_BYTES);

    ep_cfg_t           cur;
    logic [SIZE_W-1:0] foot;
    logic [BASE_W-1:0] accum_q;
    logic [BASE_W:0]   end_sum;
    logic              fits;
    logic              unused_cur;
    logic              ovf_q;
    logic [BASE_W-1:0] base_q [NUM_EP];
    logic [SIZE_W-1:0] size_q [NUM_EP];
    logic [NUM_EP-1:0] valid_q;

    always_comb begin
        cur        = cfg_all[idx];
        foot       = SIZE_W'(footprint(cur));
        end_sum    = {1'b0, accum_q} + (BASE_W + 1)'(foot);
        fits       = end_sum <= MEM_LIM;
        unused_cur = ^{cur.rsvd, cur.iso, cur.dir_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            accum_q <= '0;
            ovf_q   <= 1'b0;
        end else if (clear) begin
            accum_q <= '0;
            ovf_q   <= 1'b0;
        end else if (step) begin
            accum_q <= end_sum[BASE_W-1:0];
            if (cur.en && !fits) ovf_q <= 1'b1;
        end
    end

    for (genvar g = 0; g < NUM_EP; g++) begin : g_res
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_q[g]  <= '0;
                size_q[g]  <= '0;
                valid_q[g] <= 1'b0;
            end else if (clear) begin
                valid_q[g] <= 1'b0;
            end else if (step && idx == IDX_W'(g)) begin
                base_q[g]  <= accum_q;
                size_q[g]  <= foot;
                valid_q[g] <= cur.en && fits;
            end
        end
        assign base_flat[g*BASE_W +: BASE_W] = base_q[g];
        assign size_flat[g*SIZE_W +: SIZE_W] = size_q[g];
    end

    assign valid    = valid_q;
    assign overflow = ovf_q;

endmodule

// File: rtl/ep_fifo_allocator.sv
module ep_fifo_allocator
    import epalloc_pkg::*;
#(
    parameter  int unsigned NUM_EP    = 16,
    parameter  int unsigned MEM_BYTES = 2048,
    localparam int unsigned SIZE_W    = $clog2(2 * 1024 + 1),
    localparam int unsigned BASE_W    = $clog2(NUM_EP * 2 * 1024 + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr,
    input  logic [7:0]               cfg_code,
    input  logic [7:0]               cfg_data,
    input  logic [7:0]               rd_code,
    output logic [7:0]               rd_data,
    input  logic                     bus_reset,
    output logic [NUM_EP*BASE_W-1:0] ep_base,
    output logic [NUM_EP*SIZE_W-1:0] ep_size,
    output logic [NUM_EP-1:0]        ep_valid,
    output logic                     alloc_done,
    output logic                     alloc_overflow,
    output logic                     contents_inv
);

    localparam int unsigned IDX_W  = $clog2(NUM_EP);
    localparam logic [8:0]  WR_END = 9'(32'h20 + NUM_EP);

    logic [7:0]           wr_off;
    logic                 wr_acc;
    logic [IDX_W-1:0]     wr_idx;
    logic                 walk_step;
    logic [IDX_W-1:0]     walk_idx;
    logic                 done_w;
    logic [NUM_EP-1:0]    valid_w;
    logic                 ovf_w;
    ep_cfg_t [NUM_EP-1:0] cfg_all;

    assign wr_off = cfg_code - WR_CODE_BASE;
    assign wr_idx = wr_off[IDX_W-1:0];
    assign wr_acc = cfg_wr && !bus_reset && (cfg_code >= WR_CODE_BASE)
                    && ({1'b0, cfg_code} < WR_END);

    epalloc_cfg_table #(.NUM_EP(NUM_EP), .IDX_W(IDX_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_acc    (wr_acc),
        .wr_idx    (wr_idx),
        .wr_data   (cfg_data),
        .bus_reset (bus_reset),
        .rd_code   (rd_code),
        .rd_data   (rd_data),
        .cfg_all   (cfg_all),
        .inv_pulse (contents_inv)
    );

    epalloc_ctrl #(.NUM_EP(NUM_EP), .IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_acc     (wr_acc),
        .wr_idx     (wr_idx),
        .bus_reset  (bus_reset),
        .walk_step  (walk_step),
        .walk_idx   (walk_idx),
        .alloc_done (done_w)
    );

    epalloc_walker #(
        .NUM_EP    (NUM_EP),
        .IDX_W     (IDX_W),
        .MEM_BYTES (MEM_BYTES),
        .BASE_W    (BASE_W),
        .SIZE_W    (SIZE_W)
    ) u_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (wr_acc || bus_reset),
        .step      (walk_step),
        .idx       (walk_idx),
        .cfg_all   (cfg_all),
        .base_flat (ep_base),
        .size_flat (ep_size),
        .valid     (valid_w),
        .overflow  (ovf_w)
    );

    // Results are published only while the map is complete
    assign alloc_done     = done_w;
    assign ep_valid       = valid_w & {NUM_EP{done_w}};
    assign alloc_overflow = ovf_w & done_w;

endmodule

// File: rtl/epalloc_checker.sv
module epalloc_checker #(
    parameter int unsigned NUM_EP    = 16,
    parameter int unsigned MEM_BYTES = 2048,
    parameter int unsigned SIZE_W    = 12,
    parameter int unsigned BASE_W    = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cfg_wr,
    input logic [7:0]               cfg_code,
    input logic [7:0]               rd_code,
    input logic [7:0]               rd_data,
    input logic                     bus_reset,
    input logic [NUM_EP*BASE_W-1:0] ep_base,
    input logic [NUM_EP*SIZE_W-1:0] ep_size,
    input logic [NUM_EP-1:0]        ep_valid,
    input logic                     alloc_done,
    input logic                     contents_inv
);

    localparam logic [8:0]      WR_END  = 9'(32'h20 + NUM_EP);
    localparam logic [BASE_W:0] MEM_LIM = (BASE_W + 1)'(MEM_BYTES);

    logic wr_hit;
    assign wr_hit = cfg_wr && (cfg_code >= 8'h20) && ({1'b0, cfg_code} < WR_END);

    p_ctrl_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_code == 8'h30 || rd_code == 8'h31)
        |-> (rd_data[7:4] == 4'h3 && rd_data[3:2] == 2'b00 && rd_data[1] == rd_code[0]));

    p_done_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_done && !wr_hit && !bus_reset) |=> alloc_done);

    p_write_drops_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !bus_reset) |=> (!alloc_done && ep_valid == '0));

    p_inv_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        contents_inv |-> $past(wr_hit || bus_reset));

    p_busrst_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (!alloc_done && ep_valid == '0 && contents_inv));

    for (genvar g = 0; g < NUM_EP; g++) begin : g_slot_chk
        p_valid_size_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ep_valid[g] |-> (ep_size[g*SIZE_W +: SIZE_W] != '0));

        p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ep_valid[g] |-> (({1'b0, ep_base[g*BASE_W +: BASE_W]}
                              + (BASE_W + 1)'(ep_size[g*SIZE_W +: SIZE_W])) <= MEM_LIM));
    end

endmodule

bind ep_fifo_allocator epalloc_checker #(
    .NUM_EP    (NUM_EP),
    .MEM_BYTES (MEM_BYTES),
    .SIZE_W    (SIZE_W),
    .BASE_W    (BASE_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr       (cfg_wr),
    .cfg_code     (cfg_code),
    .rd_code      (rd_code),
    .rd_data      (rd_data),
    .bus_reset    (bus_reset),
    .ep_base      (ep_base),
    .ep_size      (ep_size),
    .ep_valid     (ep_valid),
    .alloc_done   (alloc_done),
    .contents_inv (contents_inv)
);

// File: tb/test_ep_fifo_allocator.sv
`timescale 1ns/1ps
module test_ep_fifo_allocator;

    localparam int NEP = 16;
    localparam int BW  = 16;
    localparam int SW  = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_wr = 1'b0;
    logic [7:0]      cfg_code = 8'h00;
    logic [7:0]      cfg_data = 8'h00;
    logic [7:0]      rd_code = 8'h00;
    logic [7:0]      rd_data;
    logic            bus_reset = 1'b0;
    logic [NEP*BW-1:0] ep_base;
    logic [NEP*SW-1:0] ep_size;
    logic [NEP-1:0]  ep_valid;
    logic            alloc_done;
    logic            alloc_overflow;
    logic            contents_inv;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    ep_fifo_allocator i_ep_fifo_allocator (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_wr         (cfg_wr),
        .cfg_code       (cfg_code),
        .cfg_data       (cfg_data),
        .rd_code        (rd_code),
        .rd_data        (rd_data),
        .bus_reset      (bus_reset),
        .ep_base        (ep_base),
        .ep_size        (ep_size),
        .ep_valid       (ep_valid),
        .alloc_done     (alloc_done),
        .alloc_overflow (alloc_overflow),
        .contents_inv   (contents_inv)
    );

    // Slots 2..15: {config byte, expected base, expected size, expected valid}
    localparam logic [36:0] VEC [14] = '{
        {8'h41, 16'd128,  12'd128,  1'b1},
        {8'h45, 16'd256,  12'd256,  1'b1},
        {8'h00, 16'd512,  12'd0,    1'b0},
        {8'h0B, 16'd512,  12'd8,    1'b1},
        {8'h71, 16'd520,  12'd1024, 1'b1},
        {8'h35, 16'd1544, 12'd128,  1'b1},
        {8'h21, 16'd1672, 12'd32,   1'b1},
        {8'h00, 16'd1704, 12'd0,    1'b0},
        {8'h51, 16'd1704, 12'd256,  1'b1},
        {8'h13, 16'd1960, 12'd16,   1'b1},
        {8'h25, 16'd1976, 12'd64,   1'b1},
        {8'h01, 16'd2040, 12'd8,    1'b1},
        {8'h01, 16'd2048, 12'd8,    1'b0},
        {8'h00, 16'd2056, 12'd0,    1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] code, input logic [7:0] data);
        @(negedge clk);
        cfg_wr   = 1'b1;
        cfg_code = code;
        cfg_data = data;
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] code, output logic [7:0] val);
        rd_code = code;
        #1;
        val = rd_data;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    function automatic logic [7:0] slot_cfg(input int s, input int alt_s, input logic [7:0] alt_v);
        if (s == alt_s) return alt_v;
        return VEC[s-2][36:29];
    endfunction

    // Writes slots 0..15 in order, optionally skipping one slot
    task automatic pass(input int skip_s, input int alt_s, input logic [7:0] alt_v);
        for (int s = 0; s < NEP; s++) begin
            if (s != skip_s)
                wr(8'(8'h20 + s), (s < 2) ? 8'hA5 : slot_cfg(s, alt_s, alt_v));
        end
    endtask

    logic [7:0] v;

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        chk("R1 done", int'(alloc_done), 0);
        chk("R1 valid", int'(ep_valid), 0);
        chk("R1 overflow", int'(alloc_overflow), 0);
        rd(8'h30, v); chk("R1 slot0", int'(v), 'h30);
        rd(8'h31, v); chk("R1 slot1", int'(v), 'h32);
        rd(8'h35, v); chk("R1 slot5", int'(v), 'h00);

        // Mixed map from the vector table
        wr(8'h20, 8'h00);
        chk("R8 enable change inv", int'(contents_inv), 1);
        wr(8'h21, 8'h00);
        for (int s = 2; s < NEP; s++) begin
            wr(8'(8'h20 + s), VEC[s-2][36:29]);
            if (s == 2)  chk("R8 first config inv", int'(contents_inv), 1);
            if (s == 15) chk("R4 not done at last write", int'(alloc_done), 0);
        end
        idle(20);
        chk("R4 done after ordered pass", int'(alloc_done), 1);
        chk("R6 overflow set", int'(alloc_overflow), 1);
        chk("R5 base slot0", int'(ep_base[0 +: BW]), 0);
        chk("R5 size slot0", int'(ep_size[0 +: SW]), 64);
        chk("R5 base slot1", int'(ep_base[BW +: BW]), 64);
        chk("R6 valid slot1", int'(ep_valid[1]), 1);
        for (int s = 2; s < NEP; s++) begin
            chk($sformatf("R5 base slot%0d", s), int'(ep_base[s*BW +: BW]), int'(VEC[s-2][28:13]));
            chk($sformatf("R5 size slot%0d", s), int'(ep_size[s*SW +: SW]), int'(VEC[s-2][12:1]));
            chk($sformatf("R6 valid slot%0d", s), int'(ep_valid[s]), int'(VEC[s-2][0]));
        end

        // R2 read-back and code decoding
        rd(8'h32, v); chk("R2 read slot2", int'(v), 'h41);
        rd(8'h3B, v); chk("R2 read slot11", int'(v), 'h13);
        rd(8'h40, v); chk("R2 read out of range", int'(v), 0);
        rd(8'h2F, v); chk("R2 read with write code", int'(v), 0);
        wr(8'h40, 8'hFF);
        chk("R2 bad write keeps done", int'(alloc_done), 1);
        chk("R2 bad write no inv", int'(contents_inv), 0);
        rd(8'h3F, v); chk("R2 bad write no store", int'(v), 0);
        wr(8'h1F, 8'hFF);
        chk("R2 low bad write keeps done", int'(alloc_done), 1);
        rd(8'h30, v); chk("R3 slot0 default", int'(v), 'h31);
        rd(8'h31, v); chk("R3 slot1 default", int'(v), 'h33);

        // R7/R8 direction-only write while map published
        wr(8'h25, 8'h09);
        chk("R8 direction change no inv", int'(contents_inv), 0);
        chk("R7 write drops done", int'(alloc_done), 0);
        chk("R7 write drops valid", int'(ep_valid), 0);
        rd(8'h35, v); chk("R2 stored slot5", int'(v), 'h09);
        wr(8'h25, 8'h1B);
        chk("R8 size change inv", int'(contents_inv), 1);
        idle(1);
        chk("R8 inv single cycle", int'(contents_inv), 0);

        // R3 control write ignores data
        wr(8'h20, 8'hFE);
        chk("R3 control write no inv", int'(contents_inv), 0);
        rd(8'h30, v); chk("R3 slot0 after write", int'(v), 'h31);

        // R4 pass with slot 6 skipped never completes
        pass(6, -1, 8'h00);
        idle(20);
        chk("R4 skipped slot no done", int'(alloc_done), 0);

        // Second map: slot 6 disabled
        pass(-1, 6, 8'h00);
        idle(20);
        chk("R4 done second pass", int'(alloc_done), 1);
        chk("R6 no overflow", int'(alloc_overflow), 0);
        chk("R5 base slot6", int'(ep_base[6*BW +: BW]), 520);
        chk("R5 size disabled slot6", int'(ep_size[6*SW +: SW]), 0);
        chk("R6 valid disabled slot6", int'(ep_valid[6]), 0);
        chk("R5 base slot13", int'(ep_base[13*BW +: BW]), 1016);
        chk("R5 base slot14", int'(ep_base[14*BW +: BW]), 1024);
        chk("R6 valid slot14", int'(ep_valid[14]), 1);

        // R9 bus reset
        @(negedge clk);
        bus_reset = 1'b1;
        cfg_wr    = 1'b1;
        cfg_code  = 8'h22;
        cfg_data  = 8'h00;
        @(negedge clk);
        bus_reset = 1'b0;
        cfg_wr    = 1'b0;
        chk("R9 done dropped", int'(alloc_done), 0);
        chk("R9 valid dropped", int'(ep_valid), 0);
        chk("R9 overflow dropped", int'(alloc_overflow), 0);
        chk("R9 inv pulse", int'(contents_inv), 1);
        idle(1);
        chk("R9 inv single cycle", int'(contents_inv), 0);
        rd(8'h32, v); chk("R9 slot2 disabled, write dropped", int'(v), 'h40);
        rd(8'h30, v); chk("R9 slot0 disabled", int'(v), 'h30);

        // R7 write during walk aborts it
        pass(-1, -1, 8'h00);
        wr(8'h20, 8'h00);
        idle(20);
        chk("R7 walk abort no done", int'(alloc_done), 0);
        chk("R7 walk abort no valid", int'(ep_valid), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule